// File: doc/BRIEF.md
# Shadowed Configuration Bank with Reload Commit and Interrupt Unit

This block holds the configuration words that drive the display timing and layer logic. Each word is stored twice. Software writes go to a pending copy. The display logic sees only the active copy, on `act_cfg_o`. The pending set is copied into the active set in a single cycle, and only when software asks for it through the reload control register. Software can ask for the copy to happen at once or at the next vertical blanking strobe. Because the whole set changes in one edge, the display never sees a frame built from half old and half new settings.

The block also has a four-source interrupt unit: line event, FIFO underrun, transfer error and reload done. Each source has an enable bit and a sticky status bit, and software acknowledges a source by writing ones to a clear register. The register port is a plain one-cycle write strobe with a combinational read. It has no valid/ready handshake because every write is accepted in the cycle it is presented. It therefore never applies back-pressure, and the master may issue a write on every cycle.

Top module: `shadow_cfg_reload`

## Requirements
- R1: A write to a pending configuration word (addresses 4 to 4+NREG-1, word k at 4+k) is stored on that clock edge and reads back at the same address. All pending words reset to zero.
- R2: The active words are visible on `act_cfg_o` (word k in bits [k*DW +: DW]) and read back at addresses 4+NREG+k. They change only on the edge where a reload is applied.
- R3: Writing a 1 to bit 0 of the reload register (address 0) requests an immediate reload. That bit reads 1 for one cycle. On the next edge the active set takes the pending set and the bit clears.
- R4: Writing a 1 to bit 1 of the reload register requests a reload at blanking. The bit stays set, and the active set is held, until an edge at which `vblank_i` is high. On that edge the copy is made and the bit clears.
- R5: When bits 0 and 1 are both pending, the immediate request wins. The copy happens on the next edge regardless of `vblank_i`, and both bits clear.
- R6: The status register (address 2) has bit 0 = line event, bit 1 = FIFO underrun, bit 2 = transfer error and bit 3 = reload done. A bit sets on the edge where its event is high (for reload done, the edge that applies a reload), whether or not it is enabled. The bit then stays set.
- R7: Writing to the clear register (address 3) clears each status bit written as 1 and leaves the others unchanged. An event in the same cycle as the clear wins, and that bit stays set. Address 3 reads as zero.
- R8: The interrupt enable register (address 1) uses the same bit layout as the status register. `irq_o` is high exactly when some status bit and its enable bit are both 1, and it follows the registers with no extra cycle.
- R9: After reset, the reload bits, enables, status and both configuration copies are zero and `irq_o` is low.
- R10: Writes to the status address and to the active read-back addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, accepted every cycle |
| wr_addr_i | input | AW | Write word address |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | AW | Read word address |
| rd_data_o | output | DW | Read data, combinational from `rd_addr_i` |
| vblank_i | input | 1 | Vertical blanking indication |
| line_evt_i | input | 1 | Line event pulse |
| fifo_urun_i | input | 1 | FIFO underrun event |
| xfer_err_i | input | 1 | Transfer error event |
| irq_o | output | 1 | Combined interrupt request |
| act_cfg_o | output | NREG*DW | Active configuration words, flattened |

## Verification
A write or an event lands in its register on the edge that samples it. Read data and `irq_o` show the result in the same cycle after that edge. An immediate reload appears on `act_cfg_o` one edge after the write of the reload register. A blanking reload appears on the first edge that sees `vblank_i` high. The bench drives inputs just after each rising edge and samples on the falling edge. It keeps a behavioural model that advances on the same rising edge, so each comparison falls half a cycle after the result is due. The directed checks count edges from the write to the point of sampling.

// File: rtl/shcfg_pkg.sv
package shcfg_pkg;
  // interrupt source bit positions (shared by enable, status and clear)
  localparam int unsigned NSRC     = 4;
  localparam int unsigned SRC_LINE = 0;
  localparam int unsigned SRC_URUN = 1;
  localparam int unsigned SRC_XERR = 2;
  localparam int unsigned SRC_RLD  = 3;

  // reload request bits
  localparam int unsigned RLD_NOW = 0;
  localparam int unsigned RLD_VBL = 1;

  // control word addresses
  localparam int unsigned A_RELOAD = 0;
  localparam int unsigned A_IEN    = 1;
  localparam int unsigned A_ISTAT  = 2;
  localparam int unsigned A_ICLR   = 3;
  localparam int unsigned A_CFG0   = 4;
endpackage

// File: rtl/shcfg_reload_ctrl.sv
module shcfg_reload_ctrl
  import shcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_set_i,
  input  logic       vblank_i,
  output logic [1:0] req_o,
  output logic       apply_o
);
  logic [1:0] req_q;

  // immediate request has priority; blanking request waits for vblank
  assign apply_o = req_q[RLD_NOW] | (req_q[RLD_VBL] & vblank_i);
  assign req_o   = req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= (apply_o ? 2'b00 : req_q) | req_set_i;
  end

  // R3
  imm_req_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q[RLD_NOW] && !req_set_i[RLD_NOW]) |=> !req_q[RLD_NOW]);

  // R4
  vbl_req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q[RLD_VBL] && !req_q[RLD_NOW] && !vblank_i) |=> req_q[RLD_VBL]);
endmodule

// File: rtl/shcfg_bank.sv
module shcfg_bank #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREG-1:0]    we_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               apply_i,
  output logic [NREG*DW-1:0] pend_o,
  output logic [NREG*DW-1:0] act_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_word
    logic [DW-1:0] pend_q, act_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= '0;
      else if (we_i[g]) pend_q <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       act_q <= '0;
      else if (apply_i) act_q <= pend_q;
    end

    assign pend_o[g*DW +: DW] = pend_q;
    assign act_o[g*DW +: DW]  = act_q;
  end

  // R2
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_i |=> $stable(act_o));
endmodule

// File: rtl/shcfg_irq_unit.sv
module shcfg_irq_unit #(
  parameter int unsigned NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] ev_i,
  input  logic          en_we_i,
  input  logic          clr_we_i,
  input  logic [NS-1:0] wdata_i,
  output logic [NS-1:0] en_o,
  output logic [NS-1:0] stat_o,
  output logic          irq_o
);
  logic [NS-1:0] en_q, stat_q, clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_we_i) en_q <= wdata_i;
  end

  // events take precedence over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_mask) | ev_i;
  end

  assign en_o   = en_q;
  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & en_q);

  // R6
  evt_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_i) |=> ((stat_q & $past(ev_i)) == $past(ev_i)));

  // R7
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && ((wdata_i & ev_i) == '0)) |=> ((stat_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/shadow_cfg_reload.sv
module shadow_cfg_reload
  import shcfg_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 4,
  parameter int unsigned AW   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [DW-1:0]      rd_data_o,
  input  logic               vblank_i,
  input  logic               line_evt_i,
  input  logic               fifo_urun_i,
  input  logic               xfer_err_i,
  output logic               irq_o,
  output logic [NREG*DW-1:0] act_cfg_o
);
  localparam int unsigned ACT0 = A_CFG0 + NREG;

  logic            wr_rld, wr_ien, wr_iclr;
  logic [1:0]      req_set, req_q;
  logic            apply;
  logic [NREG-1:0] cfg_we;
  logic [NSRC-1:0] ev, en_q, stat_q;
  logic [NREG*DW-1:0] pend_w, act_w;

  assign wr_rld  = wr_en_i && (wr_addr_i == AW'(A_RELOAD));
  assign wr_ien  = wr_en_i && (wr_addr_i == AW'(A_IEN));
  assign wr_iclr = wr_en_i && (wr_addr_i == AW'(A_ICLR));
  assign req_set = wr_rld ? wr_data_i[1:0] : 2'b00;

  for (genvar g = 0; g < NREG; g++) begin : g_we
    assign cfg_we[g] = wr_en_i && (wr_addr_i == AW'(A_CFG0 + g));
  end

  always_comb begin
    ev           = '0;
    ev[SRC_LINE] = line_evt_i;
    ev[SRC_URUN] = fifo_urun_i;
    ev[SRC_XERR] = xfer_err_i;
    ev[SRC_RLD]  = apply;
  end

  shcfg_reload_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_set_i(req_set), .vblank_i(vblank_i),
    .req_o(req_q), .apply_o(apply)
  );

  shcfg_bank #(.DW(DW), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .wdata_i(wr_data_i),
    .apply_i(apply), .pend_o(pend_w), .act_o(act_w)
  );

  shcfg_irq_unit #(.NS(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .en_we_i(wr_ien), .clr_we_i(wr_iclr),
    .wdata_i(wr_data_i[NSRC-1:0]), .en_o(en_q), .stat_o(stat_q), .irq_o(irq_o)
  );

  assign act_cfg_o = act_w;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AW'(A_RELOAD)) rd_data_o[1:0] = req_q;
    if (rd_addr_i == AW'(A_IEN))    rd_data_o[NSRC-1:0] = en_q;
    if (rd_addr_i == AW'(A_ISTAT))  rd_data_o[NSRC-1:0] = stat_q;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr_i == AW'(A_CFG0 + i)) rd_data_o = pend_w[i*DW +: DW];
      if (rd_addr_i == AW'(ACT0 + i))   rd_data_o = act_w[i*DW +: DW];
    end
  end
endmodule

// File: tb/shadow_cfg_reload_bench.sv
module shadow_cfg_reload_bench;
  localparam int DW = 32, NREG = 4, AW = 4;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, vblank = 0, line_evt = 0, urun = 0, xerr = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic irq;
  logic [NREG*DW-1:0] act_cfg;
  int errors = 0, checks = 0, cyc = 0;
  bit model_on = 0;

  always #2 clk = ~clk;

  shadow_cfg_reload #(.DW(DW), .NREG(NREG), .AW(AW)) u_shadow_cfg_reload (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .vblank_i(vblank), .line_evt_i(line_evt), .fifo_urun_i(urun),
    .xfer_err_i(xerr), .irq_o(irq), .act_cfg_o(act_cfg)
  );

  // behavioural reference model
  logic [DW-1:0] m_pend [NREG];
  logic [DW-1:0] m_act  [NREG];
  logic [1:0] m_req;
  logic [3:0] m_en, m_st;
  logic m_ap;
  logic [3:0] m_clr;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin m_pend[i] = '0; m_act[i] = '0; end
      m_req = 0; m_en = 0; m_st = 0;
    end else begin
      m_ap  = m_req[0] || (m_req[1] && vblank);
      m_clr = (wr_en && wr_addr == 3) ? wr_data[3:0] : 4'h0;
      if (m_ap) for (int i = 0; i < NREG; i++) m_act[i] = m_pend[i];
      m_st  = (m_st & ~m_clr) | {m_ap, xerr, urun, line_evt};
      m_req = (m_ap ? 2'b00 : m_req) | ((wr_en && wr_addr == 0) ? wr_data[1:0] : 2'b00);
      if (wr_en && wr_addr == 1) m_en = wr_data[3:0];
      if (wr_en && wr_addr >= 4 && wr_addr < 4 + NREG) m_pend[wr_addr - 4] = wr_data;
    end
  end

  function automatic logic [DW-1:0] m_read(input int a);
    if (a == 0) return {30'b0, m_req};
    if (a == 1) return {28'b0, m_en};
    if (a == 2) return {28'b0, m_st};
    if (a >= 4 && a < 4 + NREG) return m_pend[a - 4];
    if (a >= 4 + NREG && a < 4 + 2 * NREG) return m_act[a - 4 - NREG];
    return '0;
  endfunction

  function automatic string tag_of(input int a);
    if (a == 0) return "R3";
    if (a == 1) return "R8";
    if (a == 2) return "R6";
    if (a == 3) return "R7";
    if (a < 4 + NREG) return "R1";
    if (a < 4 + 2 * NREG) return "R2";
    return "R10";
  endfunction

  task automatic chk(input string req, input logic [NREG*DW-1:0] act, input logic [NREG*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-clock comparison, half a cycle after the edge
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      logic [NREG*DW-1:0] pk;
      for (int i = 0; i < NREG; i++) pk[i*DW +: DW] = m_act[i];
      chk(tag_of(int'(rd_addr)), {96'b0, rd_data}, {96'b0, m_read(int'(rd_addr))});
      chk("R8", {127'b0, irq}, {127'b0, |(m_st & m_en)});
      chk("R2", act_cfg, pk);
    end
  end

  // read address sweep
  always @(posedge clk) begin
    #1;
    rd_addr = (rd_addr >= AW'(4 + 2 * NREG)) ? '0 : rd_addr + 1'b1;
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_wr(input int a, input logic [DW-1:0] d);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    model_on = 1;
    idle(1);
    // R9 reset state
    chk("R9", {127'b0, irq}, '0);
    chk("R9", act_cfg, '0);

    // R3 immediate reload
    do_wr(4, 32'hA5A5_0001);
    do_wr(0, 32'h1);
    chk("R2", {96'b0, act_cfg[31:0]}, '0);
    idle(1);
    chk("R3", {96'b0, act_cfg[31:0]}, {96'b0, 32'hA5A5_0001});

    // R4 blanking reload
    do_wr(5, 32'hB0B0_0002);
    do_wr(0, 32'h2);
    idle(3);
    chk("R4", {96'b0, act_cfg[63:32]}, '0);
    vblank = 1; @(posedge clk); #1; vblank = 0;
    chk("R4", {96'b0, act_cfg[63:32]}, {96'b0, 32'hB0B0_0002});

    // R5 both requested: immediate wins
    do_wr(6, 32'hC0C0_0003);
    do_wr(0, 32'h3);
    idle(1);
    chk("R5", {96'b0, act_cfg[95:64]}, {96'b0, 32'hC0C0_0003});

    // R6 status latched while disabled
    line_evt = 1; @(posedge clk); #1; line_evt = 0;
    chk("R6", {127'b0, irq}, '0);
    do_wr(1, 32'h1);
    chk("R8", {127'b0, irq}, {127'b0, 1'b1});

    // R7 clear, and event beating clear
    do_wr(3, 32'h1);
    chk("R7", {127'b0, irq}, '0);
    line_evt = 1; do_wr(3, 32'h1); line_evt = 0;
    chk("R7", {127'b0, irq}, {127'b0, 1'b1});
    do_wr(3, 32'hF);
    chk("R7", {127'b0, irq}, '0);

    // R10 writes to status and active addresses ignored
    do_wr(2, 32'hF);
    do_wr(1, 32'hF);
    chk("R10", {127'b0, irq}, '0);
    do_wr(8, 32'hDEAD_BEEF);
    chk("R10", {96'b0, act_cfg[31:0]}, {96'b0, 32'hA5A5_0001});

    // mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      wr_en    = ($urandom % 3) == 0;
      wr_addr  = AW'($urandom % 13);
      wr_data  = $urandom;
      vblank   = ($urandom % 8) == 0;
      line_evt = ($urandom % 10) == 0;
      urun     = ($urandom % 15) == 0;
      xerr     = ($urandom % 15) == 0;
      @(posedge clk); #1;
    end
    wr_en = 0; vblank = 0; line_evt = 0; urun = 0; xerr = 0;
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule